// File: doc/BRIEF.md
# Receive and Transmit FIFO Control Path

This block is the queueing and flow-control core that sits between a serial shifter and the host side of a 16550-style serial controller. It holds one byte queue for received data and one for data waiting to go out. It decodes the host's FIFO control byte, tells the host when enough bytes have arrived, and flags a receive timeout when data has been sitting unread for four character times.

The host writes the control byte, reads and writes the data register through single-cycle strobes, and sees status through level outputs. The shifter side pushes received bytes or break events and pops bytes for transmission. The timeout length follows the line-control format inputs and counts a one-per-bit-period tick supplied from outside. With the FIFOs disabled, each direction collapses to a single holding register.

Top module: `rxq_fifo_ctrl`

## Requirements
- R1: After reset, cfg_q is 0x00, data_ready, break_ind, timeout_pend, overrun and trig_hit are 0, and thr_empty is 1.
- R2: A control write whose value differs from cfg_q stores (value AND 0xC9). Bit 0 enables the FIFOs, bit 1 requests a receive clear, bit 2 requests a transmit clear, and bits 7:6 pick the trigger level.
- R3: A control write equal to cfg_q has no effect: no bits change and no clear happens.
- R4: A receive clear empties the receive queue and drops data_ready, break_ind, timeout_pend and overrun. A transmit clear empties the transmit queue so that thr_empty rises. A clear wins over a push in the same cycle.
- R5: A control write that flips bit 0 clears both queues, even if bits 1 and 2 are zero.
- R6: In FIFO mode, bits 7:6 of 00, 01, 10 and 11 select trigger levels of 1, 4, 8 and 14 bytes. trig_hit is 1 when the receive count is at or above the level.
- R7: In FIFO mode, reads return received bytes oldest first. A read that removes the last byte clears data_ready and break_ind. A read of an empty queue returns 0x00.
- R8: A break strobe queues a 0x00 byte and sets both break_ind and data_ready.
- R9: A receive push while 16 bytes are queued is dropped and sets overrun.
- R10: The timeout expires after 4 × C bit ticks, where C = (lc_bits[1:0] + 5) + (lc_bits[2] ? 2 : 1) + lc_bits[3]. The count restarts on every received byte or break and on every read that leaves data queued.
- R11: On expiry, timeout_pend is set only if the receive queue is not empty. Any data read clears it.
- R12: With the FIFOs disabled, a receive overwrites a single holding register and sets data_ready. Any data read clears data_ready. trig_hit follows data_ready.
- R13: Transmit bytes leave in write order on tx_byte and advance on tx_pop. thr_empty is 1 exactly when nothing is waiting, whether in the FIFO or in the single holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value |
| cfg_q | output | 8 | Stored control byte |
| lc_bits | input | 4 | Frame format: [1:0] data bits minus 5, [2] two stop bits, [3] parity on |
| bit_tick | input | 1 | One pulse per bit period |
| rx_push | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Received break strobe |
| rd_req | input | 1 | Host data-register read strobe |
| rd_data | output | 8 | Byte returned to the host read |
| wr_req | input | 1 | Host data-register write strobe |
| wr_data | input | 8 | Byte written by the host |
| tx_pop | input | 1 | Shifter takes the current transmit byte |
| tx_byte | output | 8 | Next byte to transmit |
| data_ready | output | 1 | Receive data available |
| break_ind | output | 1 | Break seen and not yet read out |
| trig_hit | output | 1 | Receive count reached trigger level |
| timeout_pend | output | 1 | Character timeout pending |
| thr_empty | output | 1 | No transmit data waiting |
| overrun | output | 1 | Receive byte lost to a full queue |

## Verification
The bench targets these corner cases:
- A control write that repeats the stored value. A design that decodes it anyway would wipe queued data.
- A flip of the enable bit with no clear bits set. A design that missed the forced clear would leave stale bytes and a low thr_empty.
- Each trigger boundary, checked one byte below and at the level, so an off-by-one comparison shows up.
- The seventeenth byte into a full queue, which must be lost and must not corrupt the order of the other sixteen.
- The timeout, checked one tick before and at expiry for two frame formats, after a restart by a later byte, after a restart by a partial read, and with the queue already emptied. A wrong tick count, a missed restart, or a flag raised on an empty queue all show up.

// File: rtl/rxq_pkg.sv
// Shared constants and helpers for the FIFO control path.
// Assumes an 8-bit control byte and a 4-bit frame-format field.
package rxq_pkg;
    localparam int CFG_EN     = 0;
    localparam int CFG_CLR_RX = 1;
    localparam int CFG_CLR_TX = 2;
    localparam logic [7:0] CFG_KEEP = 8'hC9;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_sel_e;

    // Byte count that raises the trigger for a given selection.
    function automatic logic [4:0] trig_bytes(input trig_sel_e sel);
        case (sel)
            TRIG_1:  return 5'd1;
            TRIG_4:  return 5'd4;
            TRIG_8:  return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    // Bits per character: data + stop + optional parity.
    function automatic logic [3:0] char_bits(input logic [3:0] lc);
        logic [3:0] n;
        n = 4'd5 + {2'b00, lc[1:0]};
        n = n + (lc[2] ? 4'd2 : 4'd1);
        n = n + {3'b000, lc[3]};
        return n;
    endfunction
endpackage

// File: rtl/rxq_byte_fifo.sv
// Circular byte queue with a synchronous one-cycle clear.
// Assumes pop on empty and push on full (without pop) are ignored.
module rxq_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = empty ? '0 : mem[rd_ptr];

    // Store the incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // Advance pointers and count; clear resets all in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/rxq_cfg_decode.sv
// Holds the FIFO control byte and turns host writes into clear pulses.
// Assumes a repeated value is a no-op and an enable flip forces both clears.
module rxq_cfg_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] cfg_q,
    output logic       clr_rx,
    output logic       clr_tx,
    output logic       fifo_en,
    output logic [4:0] trig_lvl
);
    import rxq_pkg::*;

    logic take, en_flip;

    assign take     = wr && (wdata != cfg_q);
    assign en_flip  = take && (wdata[CFG_EN] ^ cfg_q[CFG_EN]);
    assign clr_rx   = take && (wdata[CFG_CLR_RX] || en_flip);
    assign clr_tx   = take && (wdata[CFG_CLR_TX] || en_flip);
    assign fifo_en  = cfg_q[CFG_EN];
    assign trig_lvl = trig_bytes(trig_sel_e'(cfg_q[7:6]));

    // Latch the masked control byte on an effective write.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= 8'h00;
        else if (take) cfg_q <= wdata & CFG_KEEP;
    end
endmodule

// File: rtl/rxq_char_timeout.sv
// Counts bit ticks after a restart and pulses expire at the limit.
// Assumes limit >= 1; restart has priority over disarm and tick.
module rxq_char_timeout #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         disarm,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic         armed;

    assign expire = armed && tick && !restart && !disarm && (cnt == limit - 1'b1);

    // Run the tick counter while armed; stop on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (disarm || expire) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (armed && tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxq_fifo_ctrl.sv
// FIFO control path: receive/transmit queues, trigger compare, timeout.
// Assumes single-cycle strobes; the shifter and baud logic live outside.
module rxq_fifo_ctrl #(
    parameter int DEPTH = 16,
    parameter int TMO_W = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_q,
    input  logic [3:0] lc_bits,
    input  logic       bit_tick,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    input  logic       rx_break,
    input  logic       rd_req,
    output logic [7:0] rd_data,
    input  logic       wr_req,
    input  logic [7:0] wr_data,
    input  logic       tx_pop,
    output logic [7:0] tx_byte,
    output logic       data_ready,
    output logic       break_ind,
    output logic       trig_hit,
    output logic       timeout_pend,
    output logic       thr_empty,
    output logic       overrun
);
    import rxq_pkg::*;

    logic             clr_rx, clr_tx, fifo_en;
    logic [4:0]       trig_lvl;
    logic             rx_in, rx_wr, rx_rd, rx_full, rx_empty;
    logic [7:0]       rx_head, rx_hold;
    logic [CNT_W-1:0] rx_count;
    logic             tx_wr, tx_rd, tx_full_f, tx_empty;
    logic [7:0]       tx_head, tx_hold;
    logic [CNT_W-1:0] tx_count;
    logic             tx_hold_full;
    logic             tmo_restart, tmo_expire;
    logic [TMO_W-1:0] tmo_limit;

    rxq_cfg_decode u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .cfg_q(cfg_q), .clr_rx(clr_rx), .clr_tx(clr_tx),
        .fifo_en(fifo_en), .trig_lvl(trig_lvl)
    );

    assign rx_in = rx_push || rx_break;
    assign rx_wr = fifo_en && !clr_rx && rx_in;
    assign rx_rd = fifo_en && !clr_rx && rd_req;

    rxq_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx), .push(rx_wr), .pop(rx_rd),
        .din(rx_break ? 8'h00 : rx_byte), .dout(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign tx_wr = fifo_en && !clr_tx && wr_req;
    assign tx_rd = fifo_en && !clr_tx && tx_pop;

    rxq_byte_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx), .push(tx_wr), .pop(tx_rd),
        .din(wr_data), .dout(tx_head),
        .count(tx_count), .full(tx_full_f), .empty(tx_empty)
    );

    assign tmo_limit   = TMO_W'({char_bits(lc_bits), 2'b00});
    assign tmo_restart = !clr_rx && (rx_wr || (rx_rd && rx_count > CNT_W'(1)));

    rxq_char_timeout #(.W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .restart(tmo_restart),
        .disarm(clr_rx || !fifo_en), .tick(bit_tick),
        .limit(tmo_limit), .expire(tmo_expire)
    );

    // Receive status flags and the non-FIFO holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_ready <= 1'b0;
            break_ind  <= 1'b0;
            overrun    <= 1'b0;
            rx_hold    <= 8'h00;
        end else if (clr_rx) begin
            data_ready <= 1'b0;
            break_ind  <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (rx_in) begin
                data_ready <= 1'b1;
                if (rx_break) break_ind <= 1'b1;
            end else if (rd_req && (!fifo_en || rx_count <= CNT_W'(1))) begin
                data_ready <= 1'b0;
                break_ind  <= 1'b0;
            end
            if (!fifo_en && rx_in) rx_hold <= rx_break ? 8'h00 : rx_byte;
            if (rx_wr && rx_full && !rx_rd) overrun <= 1'b1;
        end
    end

    // Timeout pending flag: raised on expiry with data, dropped by read or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_rx)          timeout_pend <= 1'b0;
        else if (fifo_en && rd_req)    timeout_pend <= 1'b0;
        else if (tmo_expire && !rx_empty) timeout_pend <= 1'b1;
    end

    // Transmit holding register used when the FIFOs are off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold      <= 8'h00;
            tx_hold_full <= 1'b0;
        end else if (clr_tx) begin
            tx_hold_full <= 1'b0;
        end else if (!fifo_en) begin
            if (wr_req) begin
                tx_hold      <= wr_data;
                tx_hold_full <= 1'b1;
            end else if (tx_pop) begin
                tx_hold_full <= 1'b0;
            end
        end
    end

    assign rd_data   = fifo_en ? rx_head : rx_hold;
    assign tx_byte   = fifo_en ? tx_head : tx_hold;
    assign thr_empty = fifo_en ? tx_empty : !tx_hold_full;
    assign trig_hit  = fifo_en ? (rx_count >= CNT_W'(trig_lvl)) : data_ready;
endmodule

// File: rtl/rxq_fifo_ctrl_chk.sv
// Property checker for rxq_fifo_ctrl, attached by bind.
// Assumes it sees the top-level ports only.
module rxq_fifo_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_q,
    input logic       rx_push,
    input logic       rx_break,
    input logic       rd_req,
    input logic       data_ready,
    input logic       break_ind,
    input logic       trig_hit,
    input logic       timeout_pend,
    input logic       thr_empty
);
    a_r2_masked_store: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_wdata != cfg_q) |=> cfg_q == ($past(cfg_wdata) & 8'hC9));

    a_r3_repeat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_wdata == cfg_q) && !rx_push && !rx_break && !rd_req
        |=> $stable(cfg_q) && (data_ready == $past(data_ready)));

    a_r5_flip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_wdata[0] != cfg_q[0])
        |=> !data_ready && !break_ind && !timeout_pend && thr_empty);

    a_r8_break_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break && !cfg_wr |=> break_ind && data_ready);

    a_r6_trig_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> data_ready);

    a_r11_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pend |-> data_ready);
endmodule

bind rxq_fifo_ctrl rxq_fifo_ctrl_chk u_chk (.*);

// File: tb/sim_rxq_fifo_ctrl.sv
module sim_rxq_fifo_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_q;
    logic [3:0] lc_bits = 4'h0;
    logic       bit_tick = 1'b0;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_break = 1'b0;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_byte;
    logic       data_ready, break_ind, trig_hit, timeout_pend, thr_empty, overrun;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    rxq_fifo_ctrl u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic cfg(input logic [7:0] v);
        cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    // Driver: push a receive byte and, if tracked, queue its expectation.
    task automatic rx_in(input logic [7:0] b, input bit track);
        rx_byte = b; rx_push = 1'b1;
        if (track) exp_q.push_back(b);
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic brk_in();
        rx_break = 1'b1; exp_q.push_back(8'h00);
        @(negedge clk); rx_break = 1'b0;
    endtask

    // Monitor: compare the read data against the scoreboard head, then pop.
    task automatic rd_chk(input string req);
        logic [7:0] e;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
        chk_eq(req, rd_data, e);
        rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic tx_in(input logic [7:0] b);
        wr_data = b; wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
    endtask

    task automatic tx_take();
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 cfg_q", cfg_q, 8'h00);
        chk_eq("R1 flags", {data_ready, break_ind, timeout_pend, overrun, trig_hit}, 0);
        chk_eq("R1 thr_empty", thr_empty, 1);

        // R2 masked store
        cfg(8'hFF);
        chk_eq("R2 stored mask", cfg_q, 8'hC9);

        // R3 repeated value ignored
        rx_in(8'hA1, 1); rx_in(8'hA2, 1); rx_in(8'hA3, 1);
        cfg(8'hC9);
        chk_eq("R3 cfg kept", cfg_q, 8'hC9);
        chk_eq("R3 data kept", data_ready, 1);
        rd_chk("R3 R7 order"); rd_chk("R3 R7 order"); rd_chk("R3 R7 order");
        chk_eq("R7 last read clears ready", data_ready, 0);

        // R6 trigger levels
        cfg(8'h43);
        for (int i = 0; i < 3; i++) rx_in(8'(8'h10 + i), 1);
        chk_eq("R6 below 4", trig_hit, 0);
        rx_in(8'h13, 1);
        chk_eq("R6 at 4", trig_hit, 1);
        cfg(8'h83); exp_q.delete();
        for (int i = 0; i < 7; i++) rx_in(8'(8'h20 + i), 1);
        chk_eq("R6 below 8", trig_hit, 0);
        rx_in(8'h27, 1);
        chk_eq("R6 at 8", trig_hit, 1);
        cfg(8'hC3); exp_q.delete();
        for (int i = 0; i < 13; i++) rx_in(8'(8'h30 + i), 1);
        chk_eq("R6 below 14", trig_hit, 0);
        rx_in(8'h3D, 1);
        chk_eq("R6 at 14", trig_hit, 1);
        cfg(8'h03); exp_q.delete();
        chk_eq("R4 clear rx ready", data_ready, 0);
        rx_in(8'h55, 1);
        chk_eq("R6 level 1", trig_hit, 1);
        rd_chk("R7 single");

        // R9 overrun on full queue
        for (int i = 0; i < 16; i++) rx_in(8'(8'h40 + i), 1);
        chk_eq("R9 no overrun at 16", overrun, 0);
        rx_in(8'hEE, 0);
        chk_eq("R9 overrun", overrun, 1);
        for (int i = 0; i < 16; i++) rd_chk("R9 order kept");
        chk_eq("R7 empty ready", data_ready, 0);
        rd_chk("R7 empty read zero");

        // R8 break
        rx_in(8'h66, 1); brk_in();
        chk_eq("R8 break_ind", break_ind, 1);
        chk_eq("R8 data_ready", data_ready, 1);
        rd_chk("R8 data before break");
        chk_eq("R8 break held", break_ind, 1);
        rd_chk("R8 zero byte");
        chk_eq("R7 break cleared", {break_ind, data_ready}, 0);

        // R4 clears and overrun drop
        rx_in(8'h01, 0); rx_in(8'h02, 0);
        cfg(8'h03);
        chk_eq("R4 rx clear", {data_ready, overrun}, 0);
        tx_in(8'h91); tx_in(8'h92);
        chk_eq("R13 thr busy", thr_empty, 0);
        cfg(8'h05);
        chk_eq("R4 tx clear", thr_empty, 1);

        // R5 enable flip clears both
        rx_in(8'h77, 0); tx_in(8'h88);
        cfg(8'h00);
        chk_eq("R5 flip rx", data_ready, 0);
        chk_eq("R5 flip tx", thr_empty, 1);

        // R12 non-FIFO holding register
        exp_q.delete();
        rx_in(8'h11, 0); rx_in(8'h22, 0);
        chk_eq("R12 ready", data_ready, 1);
        chk_eq("R12 trig", trig_hit, 1);
        chk_eq("R12 overwrite", rd_data, 8'h22);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        chk_eq("R12 read clears", data_ready, 0);

        // R13 transmit paths
        tx_in(8'hD0);
        chk_eq("R13 hold busy", thr_empty, 0);
        chk_eq("R13 hold byte", tx_byte, 8'hD0);
        tx_take();
        chk_eq("R13 hold empty", thr_empty, 1);
        cfg(8'h01);
        tx_in(8'hA0); tx_in(8'hB0); tx_in(8'hC0);
        chk_eq("R13 first", tx_byte, 8'hA0);
        tx_take();
        chk_eq("R13 second", tx_byte, 8'hB0);
        tx_take();
        chk_eq("R13 third", tx_byte, 8'hC0);
        chk_eq("R13 not empty", thr_empty, 0);
        tx_take();
        chk_eq("R13 empty", thr_empty, 1);

        // R10 R11 timeout, format 5N1 -> 24 ticks
        lc_bits = 4'h0;
        rx_in(8'h5A, 1);
        ticks(23);
        chk_eq("R10 before 24", timeout_pend, 0);
        ticks(1);
        chk_eq("R10 at 24", timeout_pend, 1);
        rd_chk("R11 read data");
        chk_eq("R11 read clears pend", timeout_pend, 0);
        // empty queue on expiry
        rx_in(8'h5B, 1); rd_chk("R11 drain");
        ticks(30);
        chk_eq("R11 empty no pend", timeout_pend, 0);
        // format 8 data, 2 stop, parity -> 44 ticks; restart by push and read
        lc_bits = 4'hF;
        rx_in(8'h61, 1);
        ticks(43);
        rx_in(8'h62, 1);
        ticks(43);
        chk_eq("R10 push restart", timeout_pend, 0);
        ticks(1);
        chk_eq("R10 at 44", timeout_pend, 1);
        rd_chk("R11 partial read");
        chk_eq("R11 pend cleared", timeout_pend, 0);
        ticks(43);
        chk_eq("R10 read restart", timeout_pend, 0);
        ticks(1);
        chk_eq("R10 after read restart", timeout_pend, 1);
        rd_chk("R11 final read");
        chk_eq("R11 final pend", timeout_pend, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule